// File: doc/BRIEF.md
# Per-Bank AXI Address Rebaser

This block sits on the address channels between an accelerator's memory-side AXI masters and the platform's memory ports. It has one lane per memory bank. Each bank owns a 64-bit base offset register. The block adds that offset to every write-address (AW) and read-address (AR) request headed for the bank. The sum is formed combinationally, so a request leaves in the same cycle it arrives.

The offsets reset to one shared default. At run time they are reloaded by snooping a simple configuration write port, which carries a valid strobe, an address and 32-bit data. Each bank has two configuration slots: one for the low 32 bits of its offset and one for the high 32 bits. The configuration range holds slots for up to 32 banks. Writes that land in slots for banks that are not built, or anywhere outside the range, have no effect.

The AW and AR channels follow valid/ready rules. The valid, ready, ID, burst length, beat size and burst type signals travel straight through, so back-pressure from the memory side reaches the master unchanged and the block never stalls a request on its own. The W, B and R channels do not pass through this block; they connect directly. Host software must not change a bank's offset while that bank has transactions outstanding.

Top module: `axi_bank_rebase`

## Requirements
- R1: After reset, every bank's offset equals the parameter DEFAULT_OFFSET, so each outgoing address is the incoming address plus that default.
- R2: For bank i, the outgoing AW address equals the incoming AW address plus bank i's current offset.
- R3: For bank i, the outgoing AR address equals the incoming AR address plus bank i's current offset.
- R4: The address sum is combinational: an outgoing address reflects the incoming address in the same cycle, with no added pipeline stage.
- R5: A configuration write with valid high updates bank i's offset on that clock edge. The address DCR_BASE+2i loads offset bits 31:0, the address DCR_BASE+2i+1 loads bits 63:32, and the other half is kept. The new value is visible from the next cycle.
- R6: A configuration write leaves every offset unchanged in three cases: valid is low, the address falls in the 64-slot range but targets a bank index at or above NUM_BANKS, or the address is outside the range.
- R7: The sum is truncated to ADDR_W bits, and any carry beyond that width is dropped.
- R8: The AW and AR valid, ready, ID, length (8 bits), size (3 bits) and burst (2 bits) signals pass through unmodified in both directions. The block adds no back-pressure of its own.
- R9: A write to one bank's slots leaves every other bank's offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_valid | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | DCR_ADDR_W | Configuration write address |
| cfg_wr_data | input | 32 | Configuration write data |
| s_aw_valid | input | NUM_BANKS | AW valid from the masters |
| s_aw_ready | output | NUM_BANKS | AW ready to the masters |
| s_aw_addr | input | NUM_BANKS*ADDR_W | Incoming AW addresses |
| s_aw_id | input | NUM_BANKS*ID_W | Incoming AW IDs |
| s_aw_len | input | NUM_BANKS*8 | Incoming AW burst lengths |
| s_aw_size | input | NUM_BANKS*3 | Incoming AW beat sizes |
| s_aw_burst | input | NUM_BANKS*2 | Incoming AW burst types |
| m_aw_valid | output | NUM_BANKS | AW valid to memory |
| m_aw_ready | input | NUM_BANKS | AW ready from memory |
| m_aw_addr | output | NUM_BANKS*ADDR_W | Rebased AW addresses |
| m_aw_id | output | NUM_BANKS*ID_W | Outgoing AW IDs |
| m_aw_len | output | NUM_BANKS*8 | Outgoing AW burst lengths |
| m_aw_size | output | NUM_BANKS*3 | Outgoing AW beat sizes |
| m_aw_burst | output | NUM_BANKS*2 | Outgoing AW burst types |
| s_ar_valid | input | NUM_BANKS | AR valid from the masters |
| s_ar_ready | output | NUM_BANKS | AR ready to the masters |
| s_ar_addr | input | NUM_BANKS*ADDR_W | Incoming AR addresses |
| s_ar_id | input | NUM_BANKS*ID_W | Incoming AR IDs |
| s_ar_len | input | NUM_BANKS*8 | Incoming AR burst lengths |
| s_ar_size | input | NUM_BANKS*3 | Incoming AR beat sizes |
| s_ar_burst | input | NUM_BANKS*2 | Incoming AR burst types |
| m_ar_valid | output | NUM_BANKS | AR valid to memory |
| m_ar_ready | input | NUM_BANKS | AR ready from memory |
| m_ar_addr | output | NUM_BANKS*ADDR_W | Rebased AR addresses |
| m_ar_id | output | NUM_BANKS*ID_W | Outgoing AR IDs |
| m_ar_len | output | NUM_BANKS*8 | Outgoing AR burst lengths |
| m_ar_size | output | NUM_BANKS*3 | Outgoing AR beat sizes |
| m_ar_burst | output | NUM_BANKS*2 | Outgoing AR burst types |

## Verification
The adders are driven on both channels of all four banks with several address patterns: zero, all ones, alternating bits, and values that differ per bank. Giving each bank its own offset means a swapped lane or a wrong-bank lookup shows up in the output. The all-ones address, together with an all-ones offset, exposes any width or carry mistake. Configuration writes go to single halves, to every unbuilt slot up to the 32-bank cap, to addresses just outside the range, and with the strobe low. Each such write is followed by a full readback through the adders, which separates correct half selection and decode from spill-over into neighbouring halves or banks.

// File: rtl/axi_rebase_pkg.sv
package axi_rebase_pkg;
  // Highest bank count the configuration range has slots for
  localparam int unsigned MAX_BANKS = 32;
  localparam int unsigned OFFS_W    = 64;
  localparam int unsigned CFG_DW    = 32;

  // Slot address for one half of one bank's offset: the low half sits at base+2*bank,
  // the high half directly after it
  function automatic logic [31:0] offs_slot(input logic [31:0] base,
                                            input int unsigned bank,
                                            input bit upper);
    return base + 32'(2 * bank) + (upper ? 32'd1 : 32'd0);
  endfunction
endpackage

// File: rtl/rebase_offset_reg.sv
module rebase_offset_reg
  import axi_rebase_pkg::*;
#(
  parameter int unsigned       BANK_IDX       = 0,
  parameter int unsigned       DCR_ADDR_W     = 12,
  parameter logic [31:0]       DCR_BASE       = 32'h20,
  parameter logic [OFFS_W-1:0] DEFAULT_OFFSET = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr_valid,
  input  logic [DCR_ADDR_W-1:0] cfg_wr_addr,
  input  logic [CFG_DW-1:0]     cfg_wr_data,
  output logic [OFFS_W-1:0]     offset
);
  localparam logic [DCR_ADDR_W-1:0] LO_ADDR = DCR_ADDR_W'(offs_slot(DCR_BASE, BANK_IDX, 1'b0));
  localparam logic [DCR_ADDR_W-1:0] HI_ADDR = DCR_ADDR_W'(offs_slot(DCR_BASE, BANK_IDX, 1'b1));

  logic hit_lo, hit_hi;
  logic [OFFS_W-1:0] off_q;

  assign hit_lo = cfg_wr_valid && (cfg_wr_addr == LO_ADDR);
  assign hit_hi = cfg_wr_valid && (cfg_wr_addr == HI_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q <= DEFAULT_OFFSET;
    end else begin
      if (hit_lo) off_q[31:0]  <= cfg_wr_data;
      if (hit_hi) off_q[63:32] <= cfg_wr_data;
    end
  end

  assign offset = off_q;

  // R5
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_valid && cfg_wr_addr == LO_ADDR) |=>
      (offset[31:0] == $past(cfg_wr_data)) && $stable(offset[63:32]));

  // R5
  hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_valid && cfg_wr_addr == HI_ADDR) |=>
      (offset[63:32] == $past(cfg_wr_data)) && $stable(offset[31:0]));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_valid || (cfg_wr_addr != LO_ADDR && cfg_wr_addr != HI_ADDR)) |=>
      $stable(offset));
endmodule

// File: rtl/rebase_addr_chan.sv
module rebase_addr_chan
  import axi_rebase_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned ID_W   = 4
) (
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [ID_W-1:0]   s_id,
  input  logic [7:0]        s_len,
  input  logic [2:0]        s_size,
  input  logic [1:0]        s_burst,
  input  logic [OFFS_W-1:0] offset,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [ID_W-1:0]   m_id,
  output logic [7:0]        m_len,
  output logic [2:0]        m_size,
  output logic [1:0]        m_burst
);
  localparam int unsigned PAD_W = OFFS_W - ADDR_W;

  logic [OFFS_W-1:0] sum_full;
  logic [OFFS_W-1:0] addr_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr_ext = {{PAD_W{1'b0}}, s_addr};
    end else begin : g_nopad
      assign addr_ext = s_addr;
    end
  endgenerate

  always_comb begin
    sum_full = addr_ext + offset;
    m_addr   = sum_full[ADDR_W-1:0];
  end

  assign m_valid = s_valid;
  assign s_ready = m_ready;
  assign m_id    = s_id;
  assign m_len   = s_len;
  assign m_size  = s_size;
  assign m_burst = s_burst;
endmodule

// File: rtl/axi_bank_rebase.sv
module axi_bank_rebase
  import axi_rebase_pkg::*;
#(
  parameter int unsigned       NUM_BANKS      = 4,
  parameter int unsigned       ADDR_W         = 40,
  parameter int unsigned       ID_W           = 4,
  parameter int unsigned       DCR_ADDR_W     = 12,
  parameter logic [31:0]       DCR_BASE       = 32'h20,
  parameter logic [OFFS_W-1:0] DEFAULT_OFFSET = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr_valid,
  input  logic [DCR_ADDR_W-1:0]       cfg_wr_addr,
  input  logic [CFG_DW-1:0]           cfg_wr_data,
  input  logic [NUM_BANKS-1:0]        s_aw_valid,
  output logic [NUM_BANKS-1:0]        s_aw_ready,
  input  logic [NUM_BANKS*ADDR_W-1:0] s_aw_addr,
  input  logic [NUM_BANKS*ID_W-1:0]   s_aw_id,
  input  logic [NUM_BANKS*8-1:0]      s_aw_len,
  input  logic [NUM_BANKS*3-1:0]      s_aw_size,
  input  logic [NUM_BANKS*2-1:0]      s_aw_burst,
  output logic [NUM_BANKS-1:0]        m_aw_valid,
  input  logic [NUM_BANKS-1:0]        m_aw_ready,
  output logic [NUM_BANKS*ADDR_W-1:0] m_aw_addr,
  output logic [NUM_BANKS*ID_W-1:0]   m_aw_id,
  output logic [NUM_BANKS*8-1:0]      m_aw_len,
  output logic [NUM_BANKS*3-1:0]      m_aw_size,
  output logic [NUM_BANKS*2-1:0]      m_aw_burst,
  input  logic [NUM_BANKS-1:0]        s_ar_valid,
  output logic [NUM_BANKS-1:0]        s_ar_ready,
  input  logic [NUM_BANKS*ADDR_W-1:0] s_ar_addr,
  input  logic [NUM_BANKS*ID_W-1:0]   s_ar_id,
  input  logic [NUM_BANKS*8-1:0]      s_ar_len,
  input  logic [NUM_BANKS*3-1:0]      s_ar_size,
  input  logic [NUM_BANKS*2-1:0]      s_ar_burst,
  output logic [NUM_BANKS-1:0]        m_ar_valid,
  input  logic [NUM_BANKS-1:0]        m_ar_ready,
  output logic [NUM_BANKS*ADDR_W-1:0] m_ar_addr,
  output logic [NUM_BANKS*ID_W-1:0]   m_ar_id,
  output logic [NUM_BANKS*8-1:0]      m_ar_len,
  output logic [NUM_BANKS*3-1:0]      m_ar_size,
  output logic [NUM_BANKS*2-1:0]      m_ar_burst
);
  logic [OFFS_W-1:0] bank_off [NUM_BANKS];

  generate
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      rebase_offset_reg #(
        .BANK_IDX      (i),
        .DCR_ADDR_W    (DCR_ADDR_W),
        .DCR_BASE      (DCR_BASE),
        .DEFAULT_OFFSET(DEFAULT_OFFSET)
      ) u_off (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_valid(cfg_wr_valid),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .offset      (bank_off[i])
      );

      rebase_addr_chan #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_aw (
        .s_valid(s_aw_valid[i]),
        .s_ready(s_aw_ready[i]),
        .s_addr (s_aw_addr[i*ADDR_W +: ADDR_W]),
        .s_id   (s_aw_id[i*ID_W +: ID_W]),
        .s_len  (s_aw_len[i*8 +: 8]),
        .s_size (s_aw_size[i*3 +: 3]),
        .s_burst(s_aw_burst[i*2 +: 2]),
        .offset (bank_off[i]),
        .m_valid(m_aw_valid[i]),
        .m_ready(m_aw_ready[i]),
        .m_addr (m_aw_addr[i*ADDR_W +: ADDR_W]),
        .m_id   (m_aw_id[i*ID_W +: ID_W]),
        .m_len  (m_aw_len[i*8 +: 8]),
        .m_size (m_aw_size[i*3 +: 3]),
        .m_burst(m_aw_burst[i*2 +: 2])
      );

      rebase_addr_chan #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_ar (
        .s_valid(s_ar_valid[i]),
        .s_ready(s_ar_ready[i]),
        .s_addr (s_ar_addr[i*ADDR_W +: ADDR_W]),
        .s_id   (s_ar_id[i*ID_W +: ID_W]),
        .s_len  (s_ar_len[i*8 +: 8]),
        .s_size (s_ar_size[i*3 +: 3]),
        .s_burst(s_ar_burst[i*2 +: 2]),
        .offset (bank_off[i]),
        .m_valid(m_ar_valid[i]),
        .m_ready(m_ar_ready[i]),
        .m_addr (m_ar_addr[i*ADDR_W +: ADDR_W]),
        .m_id   (m_ar_id[i*ID_W +: ID_W]),
        .m_len  (m_ar_len[i*8 +: 8]),
        .m_size (m_ar_size[i*3 +: 3]),
        .m_burst(m_ar_burst[i*2 +: 2])
      );

      // R2 R7
      aw_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_aw_valid[i] |->
          ADDR_W'(m_aw_addr[i*ADDR_W +: ADDR_W] - s_aw_addr[i*ADDR_W +: ADDR_W])
            == bank_off[i][ADDR_W-1:0]);

      // R3 R7
      ar_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ar_valid[i] |->
          ADDR_W'(m_ar_addr[i*ADDR_W +: ADDR_W] - s_ar_addr[i*ADDR_W +: ADDR_W])
            == bank_off[i][ADDR_W-1:0]);

      // R8
      handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_aw_valid[i] == s_aw_valid[i]) && (s_aw_ready[i] == m_aw_ready[i]) &&
        (m_ar_valid[i] == s_ar_valid[i]) && (s_ar_ready[i] == m_ar_ready[i]));
    end
  endgenerate
endmodule

// File: tb/axi_bank_rebase_tb.sv
module axi_bank_rebase_tb;
  localparam int unsigned NB  = 4;
  localparam int unsigned AW  = 40;
  localparam int unsigned IW  = 4;
  localparam int unsigned CAW = 12;
  localparam logic [31:0] BASE = 32'h20;
  localparam logic [63:0] DEF  = 64'h0000_0040_0000_0000;
  localparam logic [63:0] MASK = (64'd1 << AW) - 64'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_valid = 1'b0;
  logic [CAW-1:0] cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [NB-1:0] s_aw_valid = '0, s_aw_ready, m_aw_valid, m_aw_ready = '0;
  logic [NB-1:0] s_ar_valid = '0, s_ar_ready, m_ar_valid, m_ar_ready = '0;
  logic [NB*AW-1:0] s_aw_addr = '0, m_aw_addr, s_ar_addr = '0, m_ar_addr;
  logic [NB*IW-1:0] s_aw_id = '0, m_aw_id, s_ar_id = '0, m_ar_id;
  logic [NB*8-1:0] s_aw_len = '0, m_aw_len, s_ar_len = '0, m_ar_len;
  logic [NB*3-1:0] s_aw_size = '0, m_aw_size, s_ar_size = '0, m_ar_size;
  logic [NB*2-1:0] s_aw_burst = '0, m_aw_burst, s_ar_burst = '0, m_ar_burst;

  int checks = 0;
  int errors = 0;
  logic [63:0] model [NB];

  always #5 clk = ~clk;

  axi_bank_rebase #(
    .NUM_BANKS(NB), .ADDR_W(AW), .ID_W(IW), .DCR_ADDR_W(CAW),
    .DCR_BASE(BASE), .DEFAULT_OFFSET(DEF)
  ) u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [CAW-1:0] a, input logic [31:0] d, input logic v);
    @(negedge clk);
    cfg_wr_valid = v; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_valid = 1'b0;
  endtask

  // Drive one address on both channels of a bank, then compare both sums
  task automatic probe(input string req, input int b, input logic [AW-1:0] a);
    logic [63:0] exp;
    s_aw_addr[b*AW +: AW] = a;
    s_ar_addr[b*AW +: AW] = ~a;
    #1;
    exp = ({24'd0, a} + model[b]) & MASK;
    check(req, {24'd0, m_aw_addr[b*AW +: AW]}, exp);
    exp = ({24'd0, ~a} + model[b]) & MASK;
    check(req, {24'd0, m_ar_addr[b*AW +: AW]}, exp);
  endtask

  task automatic sweep(input string req);
    for (int b = 0; b < NB; b++) begin
      probe(req, b, '0);
      probe(req, b, '1);
      probe(req, b, 40'h55_5555_5555);
      probe(req, b, 40'h01_2345_6780 + 40'(b * 40'h10_0000_1000));
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) model[b] = DEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset default on every bank; R4 outputs follow in the same cycle
    sweep("R1_R4");

    // R5 load distinct offsets per bank, low then high half
    for (int b = 0; b < NB; b++) begin
      logic [31:0] lo, hi;
      lo = 32'hA000_0000 ^ 32'(b * 32'h0111_1111);
      hi = 32'(3 * b + 1);
      cfg_write(CAW'(BASE + 2 * b), lo, 1'b1);
      model[b][31:0] = lo;
      cfg_write(CAW'(BASE + 2 * b + 1), hi, 1'b1);
      model[b][63:32] = hi;
    end
    @(negedge clk);
    sweep("R2_R3_R5");

    // R5 low-only write keeps the high half; R9 other banks untouched
    cfg_write(CAW'(BASE + 4), 32'h0000_0BAD, 1'b1);
    model[2][31:0] = 32'h0000_0BAD;
    sweep("R5_R9");

    // R6 strobe low: bank 1 low slot not loaded
    cfg_write(CAW'(BASE + 2), 32'hFFFF_FFFF, 1'b0);
    sweep("R6_novalid");

    // R6 every slot of an unbuilt bank up to the cap, and just outside the range
    for (int s = 2 * NB; s < 64; s++) cfg_write(CAW'(BASE + s), 32'hDEAD_BEEF, 1'b1);
    cfg_write(CAW'(BASE - 1), 32'hDEAD_BEEF, 1'b1);
    cfg_write(CAW'(BASE + 64), 32'hDEAD_BEEF, 1'b1);
    sweep("R6_unbuilt");

    // R7 all-ones offset wraps: addr+(-1) truncated
    cfg_write(CAW'(BASE), 32'hFFFF_FFFF, 1'b1);
    cfg_write(CAW'(BASE + 1), 32'hFFFF_FFFF, 1'b1);
    model[0] = '1;
    probe("R7", 0, 40'd5);
    check("R7_wrap", {24'd0, m_aw_addr[AW-1:0]}, 64'd4);
    probe("R7", 0, '1);

    // R8 pass-through of handshake and request fields, both ready levels
    for (int pat = 0; pat < 2; pat++) begin
      @(negedge clk);
      s_aw_valid = NB'(pat ? 4'b1010 : 4'b0101);
      s_ar_valid = ~s_aw_valid;
      m_aw_ready = NB'(pat ? 4'b0110 : 4'b1001);
      m_ar_ready = ~m_aw_ready;
      s_aw_id = (NB*IW)'(pat ? 16'h3C5A : 16'hA5C3);
      s_ar_id = ~s_aw_id;
      s_aw_len = (NB*8)'(pat ? 32'h00FF_7F01 : 32'hFF00_80FE);
      s_ar_len = ~s_aw_len;
      s_aw_size = (NB*3)'(pat ? 12'h5A3 : 12'hA5C);
      s_ar_size = ~s_aw_size;
      s_aw_burst = (NB*2)'(pat ? 8'h1B : 8'hE4);
      s_ar_burst = ~s_aw_burst;
      #1;
      check("R8_awv", 64'(m_aw_valid), 64'(s_aw_valid));
      check("R8_awr", 64'(s_aw_ready), 64'(m_aw_ready));
      check("R8_arv", 64'(m_ar_valid), 64'(s_ar_valid));
      check("R8_arr", 64'(s_ar_ready), 64'(m_ar_ready));
      check("R8_id", 64'({m_aw_id, m_ar_id}), 64'({s_aw_id, s_ar_id}));
      check("R8_len", 64'({m_aw_len, m_ar_len}), 64'({s_aw_len, s_ar_len}));
      check("R8_size", 64'({m_aw_size, m_ar_size}), 64'({s_aw_size, s_ar_size}));
      check("R8_burst", 64'({m_aw_burst, m_ar_burst}), 64'({s_aw_burst, s_ar_burst}));
    end
    sweep("R2_R3_final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule